// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block sits between a set of level-sensitive device interrupt lines and a processor core. Each line has a fixed, unique urgency: line `i` has priority `i+1`, so a higher-numbered line is more urgent. The controller latches requests in a pending register, filters them through a software-writable disable mask, and compares them against the priority level of the handler that is running. It asks the core for service only when some pending, enabled line outranks that level.

When the core acknowledges, the controller returns the identity of the winning line in the same cycle. It pushes the running level onto a small internal stack and raises the level to that of the winner. A more urgent device can therefore break into a handler, while the serviced device cannot re-enter its own handler.

A handler clears its source through a clear register. It turns interrupts off globally for its exit sequence and then signals return-from-exception. That event pops the saved level and turns interrupts back on. Stack misuse (a push when the stack is full, or a pop when it is empty) sets a sticky error flag.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask (address 0), level (address 1), pending (address 2) and status (address 3, bit 0 global enable, bit 1 error) registers all read 0, and `irqReq` is 0.
- R2: Pending bit `i` becomes 1 one cycle after `srcLines[i]` is high. Writing a 1 to bit `i` at address 2 clears it, unless the line is high in that same cycle, in which case the bit stays 1.
- R3: `ackId` is the highest index `i` whose pending bit is 1, whose mask bit is 0 and whose priority `i+1` is greater than the current level. It is 0 when no line qualifies.
- R4: `irqReq` is a registered output. It is 1 in a cycle exactly when, in the previous cycle, the global enable was 1 and some line qualified under R3.
- R5: A mask bit of 1 at address 0 keeps its line out of selection and out of the request. The line is still recorded in the pending register.
- R6: An acknowledge while a line qualifies saves the current level on the stack and sets the level to `ackId+1`. An acknowledge while no line qualifies changes nothing.
- R7: While a handler runs at level `i+1`, line `i` and every lower line produce no request, and a strictly higher line does produce one.
- R8: A return-from-exception pops the most recently saved level into the level register and sets global enable to 1. When return and acknowledge arrive together, the acknowledge is ignored.
- R9: An acknowledge with all levels already saved (stack depth equals the number of lines), or a return with an empty stack, leaves the level unchanged and sets the error bit. The error bit stays 1 until reset.
- R10: A write to address 1 sets the level. A write to address 3 sets global enable from data bit 0 and leaves the error bit untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLines | input | NUM_SRC | Level-sensitive device interrupt lines |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 mask, 1 level, 2 clear/pending, 3 status |
| regWrData | input | NUM_SRC | Register write data |
| regRdData | output | NUM_SRC | Combinational register read data |
| irqAck | input | 1 | Core acknowledge of the request |
| rte | input | 1 | Return-from-exception event |
| irqReq | output | 1 | Registered interrupt request to the core |
| ackId | output | ID_W | Index of the winning line |

## Verification
Assertions check several relations on every cycle. The winner always outranks the current level. A granted acknowledge lands the level at the winner's priority. A return always restores global enable, a return on an empty stack keeps the level, the error flag never falls, and the stack pointer stays within its depth. The bench checks the rest with scenarios. A sweep over every pending pattern, mask and level compares the selection and the registered request against an arithmetic model. A nesting sequence has the disk line preempt the network handler and then unwinds both returns back to level zero. Separate runs cover stack overflow and underflow and the case where return and acknowledge arrive together.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam logic [1:0] ADDR_MASK  = 2'd0;
  localparam logic [1:0] ADDR_LEVEL = 2'd1;
  localparam logic [1:0] ADDR_CLEAR = 2'd2;
  localparam logic [1:0] ADDR_CTL   = 2'd3;

  typedef struct packed {
    logic wrMask;
    logic wrLevel;
    logic wrClear;
    logic wrCtl;
    logic push;
    logic pop;
  } picStrobe_t;
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic       irqAck,
  input  logic       rte,
  input  logic       candValid,
  output picStrobe_t strb
);
  always_comb begin
    strb.wrMask  = regWrEn && (regAddr == ADDR_MASK);
    strb.wrLevel = regWrEn && (regAddr == ADDR_LEVEL);
    strb.wrClear = regWrEn && (regAddr == ADDR_CLEAR);
    strb.wrCtl   = regWrEn && (regAddr == ADDR_CTL);
    strb.pop     = rte;
    strb.push    = irqAck && candValid && !rte;
  end
endmodule

// File: rtl/pic_dpath.sv
module pic_dpath
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int LVL_W = $clog2(NUM_SRC + 1),
  localparam int ID_W  = $clog2(NUM_SRC),
  localparam int DEPTH = NUM_SRC,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  picStrobe_t         strb,
  input  logic [1:0]         regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  input  logic [NUM_SRC-1:0] srcLines,
  output logic [NUM_SRC-1:0] regRdData,
  output logic               candValid,
  output logic [ID_W-1:0]    candId,
  output logic               irqReq,
  output logic [LVL_W-1:0]   curLevel,
  output logic [SP_W-1:0]    sp,
  output logic               err,
  output logic               globalEn
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] mask;
  logic [LVL_W-1:0]   stk [DEPTH];
  logic [SP_W-1:0]    spM1;
  logic               stkFull;
  logic               stkEmpty;
  logic [NUM_SRC-1:0] clrBits;

  assign spM1     = sp - SP_W'(1);
  assign stkFull  = (sp == SP_W'(DEPTH));
  assign stkEmpty = (sp == '0);
  assign clrBits  = strb.wrClear ? regWrData : '0;

  // Ascending scan: the last qualifying line (highest index) wins.
  always_comb begin
    candValid = 1'b0;
    candId    = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && !mask[i] && (LVL_W'(i + 1) > curLevel)) begin
        candValid = 1'b1;
        candId    = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend     <= '0;
      mask     <= '0;
      curLevel <= '0;
      sp       <= '0;
      err      <= 1'b0;
      globalEn <= 1'b0;
      irqReq   <= 1'b0;
    end else begin
      pend   <= (pend & ~clrBits) | srcLines;
      irqReq <= globalEn && candValid;
      if (strb.wrMask) mask <= regWrData;
      if (strb.pop) begin
        globalEn <= 1'b1;
        if (stkEmpty) begin
          err <= 1'b1;
        end else begin
          curLevel <= stk[spM1[IDX_W-1:0]];
          sp       <= spM1;
        end
      end else begin
        if (strb.wrCtl) globalEn <= regWrData[0];
        if (strb.push) begin
          if (stkFull) begin
            err <= 1'b1;
          end else begin
            curLevel <= LVL_W'(candId) + LVL_W'(1);
            sp       <= sp + SP_W'(1);
          end
        end else if (strb.wrLevel) begin
          curLevel <= regWrData[LVL_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push && !strb.pop && !stkFull) stk[sp[IDX_W-1:0]] <= curLevel;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_MASK:  regRdData = mask;
      ADDR_LEVEL: regRdData = NUM_SRC'(curLevel);
      ADDR_CLEAR: regRdData = pend;
      default:    regRdData = NUM_SRC'({err, globalEn});
    endcase
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int LVL_W = $clog2(NUM_SRC + 1),
  localparam int ID_W  = $clog2(NUM_SRC),
  localparam int SP_W  = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcLines,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  input  logic               irqAck,
  input  logic               rte,
  output logic               irqReq,
  output logic [ID_W-1:0]    ackId
);
  picStrobe_t       strb;
  logic             candValid;
  logic [ID_W-1:0]  candId;
  logic [LVL_W-1:0] curLevel;
  logic [SP_W-1:0]  sp;
  logic             err;
  logic             globalEn;

  assign ackId = candId;

  pic_ctrl u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .irqAck   (irqAck),
    .rte      (rte),
    .candValid(candValid),
    .strb     (strb)
  );

  pic_dpath #(.NUM_SRC(NUM_SRC)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .srcLines (srcLines),
    .regRdData(regRdData),
    .candValid(candValid),
    .candId   (candId),
    .irqReq   (irqReq),
    .curLevel (curLevel),
    .sp       (sp),
    .err      (err),
    .globalEn (globalEn)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NUM_SRC = 4,
  localparam int LVL_W = $clog2(NUM_SRC + 1),
  localparam int ID_W  = $clog2(NUM_SRC),
  localparam int SP_W  = $clog2(NUM_SRC + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             irqAck,
  input logic             rte,
  input logic             candValid,
  input logic [ID_W-1:0]  candId,
  input logic [LVL_W-1:0] curLevel,
  input logic [SP_W-1:0]  sp,
  input logic             err,
  input logic             globalEn
);
  // R3
  r3_above_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    candValid |-> (LVL_W'(candId) + LVL_W'(1)) > curLevel);

  // R6
  r6_ack_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && candValid && !rte && sp != SP_W'(NUM_SRC))
      |=> curLevel == LVL_W'($past(candId)) + LVL_W'(1));

  // R8
  r8_rte_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    rte |=> globalEn);

  // R9
  r9_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rte && sp == '0) |=> ($stable(curLevel) && err));

  // R9
  r9_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |=> err);

  // R9
  r9_sp_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    sp <= SP_W'(NUM_SRC));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .irqAck   (irqAck),
  .rte      (rte),
  .candValid(candValid),
  .candId   (candId),
  .curLevel (curLevel),
  .sp       (sp),
  .err      (err),
  .globalEn (globalEn)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] srcLines = '0;
  logic         regWrEn = 1'b0;
  logic [1:0]   regAddr = 2'd0;
  logic [N-1:0] regWrData = '0;
  logic [N-1:0] regRdData;
  logic         irqAck = 1'b0;
  logic         rte = 1'b0;
  logic         irqReq;
  logic [1:0]   ackId;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N)) u_dut (
    .clk(clk), .rstN(rstN), .srcLines(srcLines), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqAck(irqAck), .rte(rte), .irqReq(irqReq), .ackId(ackId)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = N'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    regAddr = a;
    #1;
    v = int'(regRdData);
  endtask

  task automatic pulse(input logic doAck, input logic doRte);
    @(negedge clk);
    irqAck = doAck; rte = doRte;
    @(negedge clk);
    irqAck = 1'b0; rte = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    srcLines = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic void model(input int p, input int m, input int l,
                                output int valid, output int id);
    valid = 0; id = 0;
    for (int i = 0; i < N; i++)
      if (p[i] && !m[i] && (i + 1 > l)) begin valid = 1; id = i; end
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, ev, eid;
    doReset();
    step();
    // R1 reset state
    rd(2'd0, v); chk("R1 mask", v, 0);
    rd(2'd1, v); chk("R1 level", v, 0);
    rd(2'd2, v); chk("R1 pending", v, 0);
    rd(2'd3, v); chk("R1 status", v, 0);
    chk("R1 irqReq", int'(irqReq), 0);

    // R4: disabled controller does not request; R2 pending latch
    srcLines = 4'b0010;
    step(); step();
    chk("R4 disabled irqReq", int'(irqReq), 0);
    rd(2'd2, v); chk("R2 pending set", v, 2);
    chk("R3 ackId", int'(ackId), 1);
    regWrite(2'd3, 1);
    rd(2'd3, v); chk("R10 enable write", v, 1);
    step();
    chk("R4 enabled irqReq", int'(irqReq), 1);

    // R2 clear while line low; R6 ack with no candidate
    srcLines = '0;
    regWrite(2'd2, 4'hF);
    rd(2'd2, v); chk("R2 pending cleared", v, 0);
    step();
    chk("R4 idle irqReq", int'(irqReq), 0);
    pulse(1'b1, 1'b0);
    rd(2'd1, v); chk("R6 ack without candidate", v, 0);

    // Sweep over pending, mask, level: R2 R3 R4 R5 R10
    for (int p = 0; p < 16; p++) begin
      srcLines = N'(p);
      regWrite(2'd2, 4'hF);
      rd(2'd2, v); chk("R2 clear vs line high", v, p);
      for (int m = 0; m < 16; m++) begin
        for (int l = 0; l <= N; l++) begin
          regWrite(2'd0, m);
          regWrite(2'd1, l);
          step();
          model(p, m, l, ev, eid);
          chk("R3 sweep ackId", int'(ackId), eid);
          chk("R4 R5 sweep irqReq", int'(irqReq), ev);
          if (l == 0) begin
            rd(2'd2, v); chk("R5 masked still pending", v, p);
          end
          if (m == 0) begin
            rd(2'd1, v); chk("R10 level write", v, l);
          end
        end
      end
    end
    srcLines = '0;
    regWrite(2'd2, 4'hF);
    regWrite(2'd0, 0);
    regWrite(2'd1, 0);

    // Nesting: network (line 1) then disk (line 3): R6 R7 R8
    srcLines = 4'b0010;
    step(); step();
    chk("R4 network request", int'(irqReq), 1);
    chk("R3 network id", int'(ackId), 1);
    pulse(1'b1, 1'b0);
    rd(2'd1, v); chk("R6 level after network ack", v, 2);
    step();
    chk("R7 no recursion", int'(irqReq), 0);
    srcLines = 4'b1010;
    step(); step();
    chk("R7 disk preempts", int'(irqReq), 1);
    chk("R7 disk id", int'(ackId), 3);
    pulse(1'b1, 1'b0);
    rd(2'd1, v); chk("R6 level after disk ack", v, 4);
    srcLines = 4'b0010;
    regWrite(2'd2, 4'b1000);
    regWrite(2'd3, 0);
    rd(2'd3, v); chk("R10 global disable", v, 0);
    pulse(1'b0, 1'b1);
    rd(2'd1, v); chk("R8 pop to network level", v, 2);
    rd(2'd3, v); chk("R8 re-enable", v, 1);
    step(); step();
    chk("R7 network still blocked", int'(irqReq), 0);
    srcLines = '0;
    regWrite(2'd2, 4'b0010);
    regWrite(2'd3, 0);
    pulse(1'b0, 1'b1);
    rd(2'd1, v); chk("R8 back to level zero", v, 0);
    step(); step();
    chk("R8 idle after returns", int'(irqReq), 0);
    rd(2'd3, v); chk("R9 no error after nesting", v, 1);

    // Return and acknowledge together with empty stack: R8 R9
    srcLines = 4'b0001;
    step(); step();
    chk("R4 line0 request", int'(irqReq), 1);
    pulse(1'b1, 1'b1);
    rd(2'd1, v); chk("R8 ack ignored on rte", v, 0);
    rd(2'd3, v); chk("R9 underflow error", v, 3);
    step();
    rd(2'd3, v); chk("R9 error sticky", v, 3);

    // Overflow: R9
    doReset();
    regWrite(2'd3, 1);
    srcLines = 4'b0001;
    step();
    for (int k = 0; k < N; k++) begin
      pulse(1'b1, 1'b0);
      rd(2'd1, v); chk("R6 push level", v, 1);
      regWrite(2'd1, 0);
    end
    rd(2'd3, v); chk("R9 full stack no error yet", v, 1);
    pulse(1'b1, 1'b0);
    rd(2'd1, v); chk("R9 overflow level kept", v, 0);
    rd(2'd3, v); chk("R9 overflow error", v, 3);
    for (int k = 0; k < N; k++) begin
      pulse(1'b0, 1'b1);
      rd(2'd1, v); chk("R8 pop saved zero", v, 0);
    end
    rd(2'd3, v); chk("R9 error stays", v, 3);

    // Pure underflow after fresh reset: R9
    doReset();
    pulse(1'b0, 1'b1);
    rd(2'd1, v); chk("R9 underflow level kept", v, 0);
    rd(2'd3, v); chk("R9 underflow sets error and enable", v, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule